// File: doc/BRIEF.md
# Sign-Sign LMS Adaptation Engine for a Ten-Tap Decision Feedback Equalizer

This block runs the adaptation loop of a receive-side decision feedback equalizer. In every unit interval it takes two one-bit inputs. The first is the sliced data decision. The second is an error comparator result that tells whether the current sample sits above or below a reference data level. From these it keeps an 8-bit code for the reference level and ten 6-bit tap codes. These codes drive current DACs outside the block.

All updates use sign-sign rules. The reference level is adapted only when the current decision is a one, because only then is the error comparison meaningful. The same gated error sign, multiplied by the decision made n intervals earlier, steps tap n up or down. Every counter saturates at both ends of its range. A programmable divider slows the stepping rate to reduce dither once the loop has settled. An enable input freezes all adaptation.

Top module: `ssl_dfe_adapt`

## Requirements
- R1: A synchronous active-high reset loads the reference code with 128 and every tap code with 32. It clears the decision history to all zeros and clears the rate divider.
- R2: While `adapt_en` is low, neither the reference code nor any tap code changes.
- R3: A qualifying cycle is one where `adapt_en` and `rx_bit` are both 1. In any cycle where `rx_bit` is 0, the reference code and the tap codes hold.
- R4: In a stepping qualifying cycle, the reference code rises by one when `above_ref` is 1 and falls by one when `above_ref` is 0.
- R5: Tap n (1 to 10) sits at `tap_codes[(n-1)*6 +: 6]`. In a stepping qualifying cycle, tap n rises by one when `above_ref` equals the decision received n cycles earlier, and falls by one otherwise. A 1 counts as +1 and a 0 as -1.
- R6: Decisions enter the history in every cycle after reset, whether or not `adapt_en` is high.
- R7: The reference code saturates at 0 and 255, and every tap code saturates at 0 and 63. No code ever wraps.
- R8: With `rate_sel` = K, only every 2^K-th qualifying cycle is a stepping cycle. Qualifying cycles are counted from reset or from the last stepping cycle. With K = 0, every qualifying cycle steps.
- R9: The codes are registered. A step caused by the inputs present before a clock edge becomes visible immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| adapt_en | input | 1 | Enables adaptation; low freezes all codes |
| rate_sel | input | 3 | Log2 of qualifying cycles per step |
| rx_bit | input | 1 | Current sliced decision |
| above_ref | input | 1 | 1 when the sample is above the reference level |
| ref_code | output | 8 | Reference-level DAC code |
| tap_codes | output | 60 | Ten packed 6-bit tap DAC codes, tap 1 in the low bits |

## Verification
The bench uses the default build: ten taps, an 8-bit reference, 6-bit taps and a 3-bit rate select. With this build, divider ratios from 1 to 128 can be set. Long runs of ones with a constant error drive both the reference and every tap into both saturation rails, so the tap and reference limits are reached within a few hundred cycles. Random decision streams, combined with settings of 0 and 2 for the rate select, exercise the pairing of the history with the error for every tap and the skipping of non-stepping qualifying cycles.

// File: rtl/ssl_dfe_adapt.sv
module ssl_dfe_adapt #(
  parameter int NTAPS  = 10,
  parameter int REF_W  = 8,
  parameter int TAP_W  = 6,
  parameter int RATE_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adapt_en,
  input  logic [RATE_W-1:0]      rate_sel,
  input  logic                   rx_bit,
  input  logic                   above_ref,
  output logic [REF_W-1:0]       ref_code,
  output logic [NTAPS*TAP_W-1:0] tap_codes
);
  localparam int DIV_W = (1 << RATE_W) - 1;
  localparam logic [REF_W-1:0] REF_MID = {1'b1, {(REF_W-1){1'b0}}};
  localparam logic [TAP_W-1:0] TAP_MID = {1'b1, {(TAP_W-1){1'b0}}};

  logic [NTAPS-1:0] hist;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;
  logic             qual;
  logic             step;

  assign div_lim = ~({DIV_W{1'b1}} << rate_sel);
  assign qual    = adapt_en & rx_bit;
  assign step    = qual & (div_cnt >= div_lim);

  always_ff @(posedge clk) begin
    if (rst)       div_cnt <= '0;
    else if (step) div_cnt <= '0;
    else if (qual) div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[NTAPS-2:0], rx_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) ref_code <= REF_MID;
    else if (step) begin
      if (above_ref && ref_code != '1)      ref_code <= ref_code + 1'b1;
      else if (!above_ref && ref_code != '0) ref_code <= ref_code - 1'b1;
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    logic [TAP_W-1:0] w;
    logic             up;
    assign up = (above_ref == hist[g]);
    always_ff @(posedge clk) begin
      if (rst) w <= TAP_MID;
      else if (step) begin
        if (up && w != '1)       w <= w + 1'b1;
        else if (!up && w != '0) w <= w - 1'b1;
      end
    end
    assign tap_codes[g*TAP_W +: TAP_W] = w;
  end
endmodule

// File: rtl/ssl_dfe_adapt_chk.sv
module ssl_dfe_adapt_chk #(
  parameter int NTAPS  = 10,
  parameter int REF_W  = 8,
  parameter int TAP_W  = 6,
  parameter int RATE_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   adapt_en,
  input logic [RATE_W-1:0]      rate_sel,
  input logic                   rx_bit,
  input logic                   above_ref,
  input logic [REF_W-1:0]       ref_code,
  input logic [NTAPS*TAP_W-1:0] tap_codes
);
  // R1
  reset_ref_mid_chk: assert property (@(posedge clk)
    rst |=> (ref_code == {1'b1, {(REF_W-1){1'b0}}}));
  // R2
  freeze_taps_chk: assert property (@(posedge clk) disable iff (rst)
    !adapt_en |=> $stable(tap_codes));
  // R3
  ref_hold_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_bit |=> $stable(ref_code) && $stable(tap_codes));
  // R4
  ref_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !above_ref |=> ref_code <= $past(ref_code));
  // R4
  ref_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    above_ref |=> ref_code >= $past(ref_code));
  // R7
  ref_no_wrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_code == '1) |=> (ref_code != '0));
  // R7
  ref_no_wrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_code == '0) |=> (ref_code != '1));

  for (genvar g = 0; g < NTAPS; g++) begin : g_tchk
    logic [TAP_W-1:0] w;
    assign w = tap_codes[g*TAP_W +: TAP_W];
    // R1
    reset_tap_mid_chk: assert property (@(posedge clk)
      rst |=> (w == {1'b1, {(TAP_W-1){1'b0}}}));
    // R7
    tap_no_wrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
      (w == '1) |=> (w != '0));
    // R7
    tap_no_wrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (w == '0) |=> (w != '1));
  end
endmodule

bind ssl_dfe_adapt ssl_dfe_adapt_chk #(
  .NTAPS(NTAPS), .REF_W(REF_W), .TAP_W(TAP_W), .RATE_W(RATE_W)
) u_chk (
  .clk(clk), .rst(rst), .adapt_en(adapt_en), .rate_sel(rate_sel),
  .rx_bit(rx_bit), .above_ref(above_ref), .ref_code(ref_code),
  .tap_codes(tap_codes)
);

// File: tb/tb_ssl_dfe_adapt.sv
`timescale 1ns/1ps
module tb_ssl_dfe_adapt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adapt_en = 1'b0;
  logic [2:0]  rate_sel = 3'd0;
  logic        rx_bit = 1'b0;
  logic        above_ref = 1'b0;
  logic [7:0]  ref_code;
  logic [59:0] tap_codes;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_ref;
  int m_tap [10];
  bit m_hist[10];
  int m_div;

  always #2 clk = ~clk;

  ssl_dfe_adapt dut (
    .clk(clk), .rst(rst), .adapt_en(adapt_en), .rate_sel(rate_sel),
    .rx_bit(rx_bit), .above_ref(above_ref), .ref_code(ref_code),
    .tap_codes(tap_codes)
  );

  function automatic int sat_step(int v, bit up, int maxv);
    if (up) return (v < maxv) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic model(bit r, bit e, int k, bit d, bit eh);
    bit q, s;
    if (r) begin
      m_ref = 128; m_div = 0;
      for (int i = 0; i < 10; i++) begin m_tap[i] = 32; m_hist[i] = 1'b0; end
      return;
    end
    q = e && d;
    s = q && (m_div >= (1 << k) - 1);
    if (s) begin
      m_ref = sat_step(m_ref, eh, 255);
      for (int i = 0; i < 10; i++) m_tap[i] = sat_step(m_tap[i], eh == m_hist[i], 63);
      m_div = 0;
    end else if (q) m_div++;
    for (int i = 9; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = d;
  endtask

  task automatic compare(string tag);
    checks++;
    if (int'(ref_code) != m_ref) begin
      fails++;
      $display("FAIL %s ref_code actual=%0d expected=%0d", tag, ref_code, m_ref);
    end
    for (int i = 0; i < 10; i++) begin
      checks++;
      if (int'(tap_codes[i*6 +: 6]) != m_tap[i]) begin
        fails++;
        $display("FAIL %s tap%0d actual=%0d expected=%0d", tag, i+1,
                 tap_codes[i*6 +: 6], m_tap[i]);
      end
    end
  endtask

  task automatic cyc(bit r, bit e, int k, bit d, bit eh, string tag);
    rst = r; adapt_en = e; rate_sel = 3'(k); rx_bit = d; above_ref = eh;
    model(r, e, k, d, eh);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset loads mid-scale codes
    cyc(1, 0, 0, 0, 0, "R1");
    cyc(1, 1, 0, 1, 1, "R1");
    // R2: enable low freezes everything while history still fills
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, $urandom & 1, $urandom & 1, "R2");
    // R6: history filled above while disabled is used by the first steps
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 1, $urandom & 1, "R6");
    // R3: zero decisions hold codes
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, $urandom & 1, "R3");
    // R5: fresh reset, history zero, error high steps taps down
    cyc(1, 0, 0, 0, 0, "R1");
    cyc(0, 1, 0, 1, 1, "R5");
    cyc(0, 1, 0, 1, 0, "R5");
    // R7: saturate everything high, then low
    for (int i = 0; i < 300; i++) cyc(0, 1, 0, 1, 1, "R7");
    for (int i = 0; i < 300; i++) cyc(0, 1, 0, 1, 0, "R7");
    // R8: divided step rate
    cyc(1, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 200; i++) cyc(0, 1, 2, $urandom & 1, $urandom & 1, "R8");
    for (int i = 0; i < 40; i++) cyc(0, 1, 7, 1, 1, "R8");
    // R4 R5 R9: random stream at full rate with occasional disable
    for (int i = 0; i < 3000; i++)
      cyc(0, ($urandom % 8) != 0, ($urandom % 16 == 0) ? 1 : 0,
          $urandom & 1, $urandom & 1, "R4_R5_R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule